// File: doc/BRIEF.md
# Amplifier Offset Trim Calibration Sequencer

This block runs the offset calibration of a rail-to-rail amplifier whose input stage has two separate differential pairs, one NMOS and one PMOS. It drives the amplifier enable, the user-trim select and the calibration-on control. It puts the amplifier in comparator mode against an internal reference and then searches the 5-bit trim code of each pair upward from zero. The NMOS pair is searched first, against the high reference. The PMOS pair is searched second, against the low reference.

After each new trim code the sequencer waits a programmable settle time. It then samples the amplifier's comparator output flag, which arrives asynchronously and passes through a two-flop synchronizer. The first code at which the sampled flag reads low becomes the result for that pair. If every code up to 31 leaves the flag high, the sequencer keeps 31 and raises a fail flag for that pair. When both pairs are done, calibration mode is released. The amplifier stays enabled and keeps using the user trim, so the two stored codes take effect.

Top module: `trim_cal_seq`

## Requirements
- R1: While reset is asserted and after its release, all control outputs, both trim codes, both fail flags, busy and done are 0, and the reference select is 00.
- R2: A start pulse seen while idle or done sets the amplifier enable, the user-trim select, calibration-on and busy on the next cycle. It also clears done, both fail flags and both trim codes.
- R3: The NMOS pair is searched first with reference select 11 (high reference). The PMOS pair is searched next with reference select 01 (low reference). Once the sequence ends, the reference select returns to 00.
- R4: During a pair's search its trim code starts at 0 and only ever steps up by exactly one. The trim code of the pair not being searched does not change.
- R5: Each trim code is held for exactly settle_cycles_i + 3 clock cycles before the next step or the end of the pair. The synchronized flag used at that decision reflects the raw flag sampled after the code was applied.
- R6: A pair's search stops at the first code whose synchronized flag is 0, and that code stays on the pair's trim output as its result.
- R7: If the flag is still 1 at code 31, the pair's result is 31 and its fail flag is set.
- R8: When the PMOS search ends, calibration-on and busy fall and done rises. Amplifier enable and user-trim stay high. Results, fail flags and done hold until the next start.
- R9: A start pulse during a search has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin calibration |
| settle_cycles_i | input | SETTLE_W | Extra wait cycles after each trim write |
| outflag_i | input | 1 | Asynchronous amplifier comparator output flag |
| amp_en_o | output | 1 | Amplifier enable |
| user_trim_o | output | 1 | Select user trim codes instead of factory codes |
| cal_on_o | output | 1 | Calibration mode: both inputs tied to the reference |
| ref_sel_o | output | 2 | Internal reference level select |
| trim_n_o | output | TRIM_W | NMOS pair trim code |
| trim_p_o | output | TRIM_W | PMOS pair trim code |
| busy_o | output | 1 | A pair search is in progress |
| done_o | output | 1 | Sequence finished |
| fail_n_o | output | 1 | NMOS search reached 31 without the flag falling |
| fail_p_o | output | 1 | PMOS search reached 31 without the flag falling |

## Verification
The bench runs flag thresholds that fall at code 0 and in mid-range. It also runs a flag that never falls, across several settle values. A design that sampled the flag too early would act on the previous code's flag and stop one code late. An off-by-one settle counter would shift every later step by a cycle. A design that saturated wrongly would wrap to 0 or miss the fail flag at code 31. A start pulse injected mid-search targets a sequencer that restarts, which would clear the NMOS result.

// File: rtl/trim_cal_pkg.sv
package trim_cal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_NPAIR = 2'd1,
    ST_PPAIR = 2'd2,
    ST_DONE  = 2'd3
  } cal_state_e;

  localparam logic [1:0] REF_OFF  = 2'b00;
  localparam logic [1:0] REF_LOW  = 2'b01;
  localparam logic [1:0] REF_HIGH = 2'b11;

  localparam int NUM_PAIRS = 2;
  localparam int PAIR_N = 0;
  localparam int PAIR_P = 1;
endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign expire_o = (cnt_q >= limit_i);
  assign cnt_en   = clear_i | ~expire_o;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)        cnt_d = '0;
    else if (!expire_o) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // The limit is always at least the synchronizer depth, so a fresh wait never ends at once.
  assert_no_instant_expire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !expire_o);
endmodule

// File: rtl/trim_code_reg.sv
module trim_code_reg #(
  parameter int TRIM_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [TRIM_W-1:0] code_o
);
  logic [TRIM_W-1:0] code_q;
  logic [TRIM_W-1:0] code_d;
  logic              code_en;

  assign code_en = clr_i | inc_i;

  always_comb begin
    code_d = code_q;
    if (clr_i)      code_d = '0;
    else if (inc_i) code_d = code_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (code_en) code_q <= code_d;
  end

  assign code_o = code_q;

  assert_clear_to_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (code_o == '0));
  assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !inc_i) |=> $stable(code_o));
endmodule

// File: rtl/trim_cal_seq.sv
module trim_cal_seq
  import trim_cal_pkg::*;
#(
  parameter int TRIM_W      = 5,
  parameter int SETTLE_W    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [SETTLE_W-1:0] settle_cycles_i,
  input  logic                outflag_i,
  output logic                amp_en_o,
  output logic                user_trim_o,
  output logic                cal_on_o,
  output logic [1:0]          ref_sel_o,
  output logic [TRIM_W-1:0]   trim_n_o,
  output logic [TRIM_W-1:0]   trim_p_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                fail_n_o,
  output logic                fail_p_o
);
  localparam int CNT_W = SETTLE_W + 2;

  cal_state_e st_q, st_d;
  logic flag_s, expire, searching, decide, at_max;
  logic found, exhausted, step, finish, start_ok;
  logic [CNT_W-1:0] wait_limit;
  logic [TRIM_W-1:0] cur_code;
  logic [TRIM_W-1:0] code [NUM_PAIRS];
  logic [NUM_PAIRS-1:0] pair_act;
  logic [NUM_PAIRS-1:0] fail_q, fail_d;
  logic amp_en_q, amp_en_d, utrim_q, utrim_d, cal_on_q, cal_on_d, done_q, done_d;
  logic [1:0] ref_q, ref_d;

  flag_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(outflag_i), .q_o(flag_s));

  assign wait_limit = CNT_W'(settle_cycles_i) + CNT_W'(SYNC_STAGES);

  settle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear_i(start_ok | step | finish),
    .limit_i(wait_limit), .expire_o(expire));

  assign pair_act[PAIR_N] = (st_q == ST_NPAIR);
  assign pair_act[PAIR_P] = (st_q == ST_PPAIR);

  genvar gp;
  generate
    for (gp = 0; gp < NUM_PAIRS; gp++) begin : g_pair
      trim_code_reg #(.TRIM_W(TRIM_W)) u_code (
        .clk(clk), .rst_n(rst_n), .clr_i(start_ok),
        .inc_i(step & pair_act[gp]), .code_o(code[gp]));
      always_comb begin
        fail_d[gp] = fail_q[gp];
        if (start_ok)                      fail_d[gp] = 1'b0;
        else if (exhausted && pair_act[gp]) fail_d[gp] = 1'b1;
      end
    end
  endgenerate

  assign searching = pair_act[PAIR_N] | pair_act[PAIR_P];
  assign start_ok  = start_i & ((st_q == ST_IDLE) | (st_q == ST_DONE));
  assign cur_code  = pair_act[PAIR_P] ? code[PAIR_P] : code[PAIR_N];
  assign at_max    = &cur_code;
  assign decide    = searching & expire;
  assign found     = decide & ~flag_s;
  assign exhausted = decide & flag_s & at_max;
  assign step      = decide & flag_s & ~at_max;
  assign finish    = found | exhausted;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE, ST_DONE: if (start_ok) st_d = ST_NPAIR;
      ST_NPAIR:         if (finish)   st_d = ST_PPAIR;
      ST_PPAIR:         if (finish)   st_d = ST_DONE;
      default:                        st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    amp_en_d = amp_en_q;
    utrim_d  = utrim_q;
    cal_on_d = cal_on_q;
    done_d   = done_q;
    ref_d    = ref_q;
    if (start_ok) begin
      amp_en_d = 1'b1;
      utrim_d  = 1'b1;
      cal_on_d = 1'b1;
      done_d   = 1'b0;
      ref_d    = REF_HIGH;
    end else if (finish && pair_act[PAIR_N]) begin
      ref_d    = REF_LOW;
    end else if (finish && pair_act[PAIR_P]) begin
      cal_on_d = 1'b0;
      done_d   = 1'b1;
      ref_d    = REF_OFF;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      amp_en_q <= 1'b0;
      utrim_q  <= 1'b0;
      cal_on_q <= 1'b0;
      done_q   <= 1'b0;
      ref_q    <= REF_OFF;
      fail_q   <= '0;
    end else begin
      st_q     <= st_d;
      amp_en_q <= amp_en_d;
      utrim_q  <= utrim_d;
      cal_on_q <= cal_on_d;
      done_q   <= done_d;
      ref_q    <= ref_d;
      fail_q   <= fail_d;
    end
  end

  assign amp_en_o    = amp_en_q;
  assign user_trim_o = utrim_q;
  assign cal_on_o    = cal_on_q;
  assign ref_sel_o   = ref_q;
  assign trim_n_o    = code[PAIR_N];
  assign trim_p_o    = code[PAIR_P];
  assign busy_o      = searching;
  assign done_o      = done_q;
  assign fail_n_o    = fail_q[PAIR_N];
  assign fail_p_o    = fail_q[PAIR_P];

  assert_ref_matches_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (ref_sel_o == (pair_act[PAIR_N] ? REF_HIGH : REF_LOW)));
  assert_n_code_steps_by_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pair_act[PAIR_N] |=> (trim_n_o == $past(trim_n_o)) ||
                         (trim_n_o == TRIM_W'($past(trim_n_o) + 1'b1)));
  assert_fail_holds_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_n_o |-> (&trim_n_o)) and (fail_p_o |-> (&trim_p_o)));
  assert_done_releases_cal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!cal_on_o && !busy_o && amp_en_o && user_trim_o));
  assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !finish) |=> busy_o && cal_on_o);
endmodule

// File: tb/tb_trim_cal_seq.sv
`timescale 1ns/1ps
module tb_trim_cal_seq;
  localparam int TRIM_W = 5;
  localparam int SETTLE_W = 16;

  logic clk, rst_n, start_i, outflag_i;
  logic [SETTLE_W-1:0] settle_cycles_i;
  logic amp_en_o, user_trim_o, cal_on_o, busy_o, done_o, fail_n_o, fail_p_o;
  logic [1:0] ref_sel_o;
  logic [TRIM_W-1:0] trim_n_o, trim_p_o;

  trim_cal_seq #(.TRIM_W(TRIM_W), .SETTLE_W(SETTLE_W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .settle_cycles_i(settle_cycles_i),
    .outflag_i(outflag_i), .amp_en_o(amp_en_o), .user_trim_o(user_trim_o),
    .cal_on_o(cal_on_o), .ref_sel_o(ref_sel_o), .trim_n_o(trim_n_o), .trim_p_o(trim_p_o),
    .busy_o(busy_o), .done_o(done_o), .fail_n_o(fail_n_o), .fail_p_o(fail_p_o));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  bit cmp_en = 0;
  int thr_n = 0, thr_p = 0;

  // Behavioural reference: phase 0 idle, 1 NMOS, 2 PMOS, 3 done.
  int m_phase, m_cnt, m_cn, m_cp;
  bit m_fn, m_fp, m_amp, m_ut, m_cal, m_done;
  bit m_s1, m_s2;
  int m_ref;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_cn = 0; m_cp = 0; m_fn = 0; m_fp = 0;
      m_amp = 0; m_ut = 0; m_cal = 0; m_done = 0; m_s1 = 0; m_s2 = 0; m_ref = 0;
    end else begin
      bit fs;
      fs = m_s2;
      m_s2 = m_s1;
      m_s1 = outflag_i;
      if ((m_phase == 0 || m_phase == 3) && start_i) begin
        m_phase = 1; m_cnt = 0; m_cn = 0; m_cp = 0; m_fn = 0; m_fp = 0;
        m_amp = 1; m_ut = 1; m_cal = 1; m_done = 0; m_ref = 3;
      end else if (m_phase == 1 || m_phase == 2) begin
        if (m_cnt >= int'(settle_cycles_i) + 2) begin
          int code;
          code = (m_phase == 1) ? m_cn : m_cp;
          m_cnt = 0;
          if (fs && code < 31) begin
            if (m_phase == 1) m_cn++; else m_cp++;
          end else begin
            if (fs) begin
              if (m_phase == 1) m_fn = 1; else m_fp = 1;
            end
            if (m_phase == 1) begin
              m_phase = 2; m_ref = 1;
            end else begin
              m_phase = 3; m_ref = 0; m_cal = 0; m_done = 1;
            end
          end
        end else m_cnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && cmp_en) begin
      chk(amp_en_o == m_amp, "R2", "amp_en", amp_en_o, m_amp);
      chk(user_trim_o == m_ut, "R8", "user_trim", user_trim_o, m_ut);
      chk(cal_on_o == m_cal, "R8", "cal_on", cal_on_o, m_cal);
      chk(busy_o == (m_phase == 1 || m_phase == 2), "R9", "busy", busy_o, (m_phase == 1 || m_phase == 2));
      chk(done_o == m_done, "R8", "done", done_o, m_done);
      chk(int'(ref_sel_o) == m_ref, "R3", "ref_sel", ref_sel_o, m_ref);
      chk(int'(trim_n_o) == m_cn, "R5", "trim_n", trim_n_o, m_cn);
      chk(int'(trim_p_o) == m_cp, "R4", "trim_p", trim_p_o, m_cp);
      chk(fail_n_o == m_fn && fail_p_o == m_fp, "R7", "fail_np", {fail_n_o, fail_p_o}, {m_fn, m_fp});
    end
    if (m_phase == 1) outflag_i <= (m_cn < thr_n);
    else if (m_phase == 2) outflag_i <= (m_cp < thr_p);
    else outflag_i <= 1'b1;
  end

  task automatic pulse_start();
    @(negedge clk); start_i <= 1'b1;
    @(negedge clk); start_i <= 1'b0;
  endtask

  task automatic run_cal(input int settle, input int tn, input int tp, input bit poke);
    int waited;
    settle_cycles_i = SETTLE_W'(settle);
    thr_n = tn; thr_p = tp;
    pulse_start();
    if (poke) begin
      repeat (settle * 4 + 10) @(negedge clk);
      start_i <= 1'b1;   // R9: start during an active search
      @(negedge clk); start_i <= 1'b0;
    end
    waited = 0;
    while (!(m_phase == 3) && waited < 20000) begin @(negedge clk); waited++; end
    repeat (15) @(negedge clk);
    chk(done_o == 1'b1, "R8", "done after run", done_o, 1);
    chk(int'(trim_n_o) == ((tn > 31) ? 31 : tn), "R6", "n result", trim_n_o, (tn > 31) ? 31 : tn);
    chk(int'(trim_p_o) == ((tp > 31) ? 31 : tp), "R6", "p result", trim_p_o, (tp > 31) ? 31 : tp);
    chk(fail_n_o == (tn > 31), "R7", "n fail", fail_n_o, tn > 31);
    chk(fail_p_o == (tp > 31), "R7", "p fail", fail_p_o, tp > 31);
    chk(cal_on_o == 1'b0 && amp_en_o && user_trim_o, "R8", "controls after done",
        {cal_on_o, amp_en_o, user_trim_o}, 3);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; outflag_i = 1'b1; settle_cycles_i = '0;
    repeat (3) @(negedge clk);
    chk({amp_en_o, user_trim_o, cal_on_o, busy_o, done_o, fail_n_o, fail_p_o} == 7'd0,
        "R1", "ctrl in reset", {amp_en_o, user_trim_o, cal_on_o, busy_o, done_o}, 0);
    chk(ref_sel_o == 2'b00 && trim_n_o == 0 && trim_p_o == 0, "R1", "codes in reset",
        {ref_sel_o, trim_n_o, trim_p_o}, 0);
    rst_n = 1'b1;
    cmp_en = 1;
    repeat (4) @(negedge clk);
    chk(busy_o == 0 && done_o == 0, "R1", "idle after reset", {busy_o, done_o}, 0);
    pulse_start();
    chk(amp_en_o && user_trim_o && cal_on_o && busy_o && ref_sel_o == 2'b11, "R2",
        "start controls", {amp_en_o, user_trim_o, cal_on_o, busy_o}, 15);
    while (m_phase != 3) @(negedge clk);
    run_cal(0, 5, 12, 0);
    run_cal(3, 0, 0, 0);
    run_cal(7, 40, 20, 1);
    run_cal(1, 31, 40, 0);
    run_cal(2, 17, 3, 1);
    cmp_en = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    while (cycles < 150000) @(negedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule